// File: doc/BRIEF.md
# Saturating Pulse-Width Measurement Counter

This block turns the width of an incoming measurement pulse into a 10-bit digital word. While the pulse gate is high, the block lets clock-enable ticks of a known rate through to a counter. The count present when the gate falls becomes the result. Several measurement sources take turns on the same gate input, so one counter serves all of them. The source select is captured with each pulse and reported alongside the result. The ticks that pass through the gate are also exported, so a downstream integrator can follow the same count clock.

Two formats are available, chosen per pulse:

- **Signed format.** The slow tick drives a 9-bit magnitude. The sign comes from a polarity bit captured at gate start.
- **Magnitude-only format.** The fast tick drives all 10 bits. A negative input reads as zero.

In both formats the magnitude sticks at all ones rather than wrapping, so an off-scale pulse can never read as a small value.

Top module: `pulse_width_meter`

## Requirements
- R1: While reset is active and after its release, `result_o` is 0, `result_src_o` is 0, `done_o` is 0 and `count_en_o` is 0 until the first measurement completes.
- R2: A rising edge of `gate_i` clears the count. Ticks are counted only in cycles after that rising-edge cycle while `gate_i` stays high. `unipolar_i`, `polarity_i` and `src_sel_i` are captured at the rising edge, and changing them later in the pulse has no effect on that measurement.
- R3: In signed format (`unipolar_i`=0 at capture), only `tick_slow_i` is counted. `result_o[9]` is the captured polarity (1 = negative) and `result_o[8:0]` is the tick count.
- R4: In magnitude-only format (`unipolar_i`=1 at capture), only `tick_fast_i` is counted, and `result_o[9:0]` is the tick count.
- R5: The magnitude saturates and never wraps: at 511 in signed format and at 1023 in magnitude-only format.
- R6: In magnitude-only format with captured polarity 1 (negative), `result_o` is 0 whatever the count.
- R7: The result and source tag are latched at the falling edge of `gate_i`. Both appear, together with a `done_o` pulse exactly one cycle long, in the cycle after the clock edge that first sees `gate_i` low.
- R8: `result_o` and `result_src_o` hold their values between `done_o` pulses.
- R9: `count_en_o` is high exactly in the cycles where a tick of the captured rate is counted. It is low during the rising-edge cycle, the falling-edge cycle and outside pulses.
- R10: `result_src_o` equals the `src_sel_i` value captured at the rising edge of the pulse being reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Measurement pulse; high while the width is being measured |
| polarity_i | input | 1 | Input polarity, 1 = negative; captured at gate start |
| src_sel_i | input | 2 | Source currently using the gate; captured at gate start |
| unipolar_i | input | 1 | 1 = magnitude-only format, 0 = signed format; captured at gate start |
| tick_slow_i | input | 1 | Clock-enable pulse of the slow scaling rate (signed format) |
| tick_fast_i | input | 1 | Clock-enable pulse of the fast scaling rate (magnitude-only format) |
| result_o | output | 10 | Latched measurement word |
| result_src_o | output | 2 | Source tag of the latched word |
| done_o | output | 1 | One-cycle strobe when a new word is latched |
| count_en_o | output | 1 | Gated count clock: ticks that advance the counter |

## Verification
The bench builds the block with its default parameters: a 10-bit word and four sources. With these values both saturation points (511 and 1023 ticks) lie within a pulse of about a thousand cycles, so both clamps are reached directly with dense ticks. Random pulses of varied length, tick density, format, polarity and source check the count and the gated count clock cycle by cycle. Directed cases cover the following:

- a one-cycle pulse;
- a pulse restarting right after a fall;
- ticks of the unselected rate;
- mode and polarity changes in mid-pulse;
- the negative-input clamp in magnitude-only format.

// File: rtl/pwmeas_pkg.sv
package pwmeas_pkg;
  typedef enum logic {
    FMT_SIGNED = 1'b0,
    FMT_MAG    = 1'b1
  } fmt_e;
endpackage

// File: rtl/pwmeas_edge.sv
module pwmeas_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o,
  output logic fall_o,
  output logic active_o
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o   =  gate_i & ~gate_q;
  assign fall_o   = ~gate_i &  gate_q;
  assign active_o =  gate_i &  gate_q;
endmodule

// File: rtl/pwmeas_ctx.sv
module pwmeas_ctx
  import pwmeas_pkg::*;
#(
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             unipolar_i,
  input  logic             polarity_i,
  input  logic [SRC_W-1:0] src_i,
  output fmt_e             fmt_o,
  output logic             sign_o,
  output logic [SRC_W-1:0] src_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_o  <= FMT_SIGNED;
      sign_o <= 1'b0;
      src_o  <= '0;
    end else if (capture_i) begin
      fmt_o  <= unipolar_i ? FMT_MAG : FMT_SIGNED;
      sign_o <= polarity_i;
      src_o  <= src_i;
    end
  end
endmodule

// File: rtl/pwmeas_counter.sv
module pwmeas_counter
  import pwmeas_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             active_i,
  input  fmt_e             fmt_i,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cnt_clk_o
);
  localparam logic [CNT_W-1:0] LIM_MAG = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_SGN = {1'b0, {(CNT_W-1){1'b1}}};

  function automatic logic [CNT_W-1:0] sat_limit(input fmt_e f);
    return (f == FMT_MAG) ? LIM_MAG : LIM_SGN;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input fmt_e f);
    return (c == sat_limit(f)) ? c : c + 1'b1;
  endfunction

  logic tick_sel;
  assign tick_sel  = (fmt_i == FMT_MAG) ? tick_fast_i : tick_slow_i;
  assign cnt_clk_o = active_i & tick_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_o <= '0;
    else if (clear_i)   count_o <= '0;
    else if (cnt_clk_o) count_o <= step(count_o, fmt_i);
  end
endmodule

// File: rtl/pwmeas_format.sv
module pwmeas_format
  import pwmeas_pkg::*;
#(
  parameter int OUT_W = 10,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_i,
  input  logic [OUT_W-1:0] count_i,
  input  logic             sign_i,
  input  fmt_e             fmt_i,
  input  logic [SRC_W-1:0] src_i,
  output logic [OUT_W-1:0] result_o,
  output logic [SRC_W-1:0] result_src_o,
  output logic             done_o
);
  function automatic logic [OUT_W-1:0] pack_word(input logic [OUT_W-1:0] c,
                                                 input logic s,
                                                 input fmt_e f);
    logic [OUT_W-1:0] w;
    if (f == FMT_MAG) w = s ? '0 : c;
    else              w = {s, c[OUT_W-2:0]};
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o     <= '0;
      result_src_o <= '0;
      done_o       <= 1'b0;
    end else begin
      done_o <= latch_i;
      if (latch_i) begin
        result_o     <= pack_word(count_i, sign_i, fmt_i);
        result_src_o <= src_i;
      end
    end
  end
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
  import pwmeas_pkg::*;
#(
  parameter int OUT_W   = 10,
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic             polarity_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic             unipolar_i,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  output logic [OUT_W-1:0] result_o,
  output logic [SRC_W-1:0] result_src_o,
  output logic             done_o,
  output logic             count_en_o
);
  logic             gate_rise_w;
  logic             gate_fall_w;
  logic             measuring_w;
  fmt_e             fmt_w;
  logic             sign_w;
  logic [SRC_W-1:0] src_w;
  logic [OUT_W-1:0] count_w;

  pwmeas_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_i   (gate_i),
    .rise_o   (gate_rise_w),
    .fall_o   (gate_fall_w),
    .active_o (measuring_w)
  );

  pwmeas_ctx #(.SRC_W(SRC_W)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (gate_rise_w),
    .unipolar_i (unipolar_i),
    .polarity_i (polarity_i),
    .src_i      (src_sel_i),
    .fmt_o      (fmt_w),
    .sign_o     (sign_w),
    .src_o      (src_w)
  );

  pwmeas_counter #(.CNT_W(OUT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (gate_rise_w),
    .active_i    (measuring_w),
    .fmt_i       (fmt_w),
    .tick_slow_i (tick_slow_i),
    .tick_fast_i (tick_fast_i),
    .count_o     (count_w),
    .cnt_clk_o   (count_en_o)
  );

  pwmeas_format #(.OUT_W(OUT_W), .SRC_W(SRC_W)) u_fmt (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch_i      (gate_fall_w),
    .count_i      (count_w),
    .sign_i       (sign_w),
    .fmt_i        (fmt_w),
    .src_i        (src_w),
    .result_o     (result_o),
    .result_src_o (result_src_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/pulse_width_meter_chk.sv
module pulse_width_meter_chk
  import pwmeas_pkg::*;
#(
  parameter int OUT_W = 10,
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_o,
  input logic [OUT_W-1:0] result_o,
  input logic [SRC_W-1:0] result_src_o,
  input logic             count_en_o,
  input logic             gate_rise_w,
  input logic             gate_fall_w,
  input logic             measuring_w,
  input fmt_e             fmt_w,
  input logic             sign_w,
  input logic [OUT_W-1:0] count_w
);
  localparam logic [OUT_W-1:0] CAP_SGN = {1'b0, {(OUT_W-1){1'b1}}};

  // R7: done lasts exactly one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done only follows a falling edge of the gate
  p_done_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(gate_fall_w));

  // R8: outputs hold between done pulses
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(result_src_o)));

  // R5: within a measurement the count never wraps downward
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (measuring_w && !gate_rise_w) |=> (count_w >= $past(count_w)));

  // R5: signed format never exceeds the 9-bit cap
  p_signed_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_w == FMT_SIGNED) |-> (count_w <= CAP_SGN));

  // R6: negative input in magnitude-only format reads zero
  p_unipolar_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fmt_w == FMT_MAG && sign_w) |-> (result_o == '0));

  // R9: gated count clock only while measuring
  p_cnt_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count_en_o |-> measuring_w);

  // R2: the counter is zero right after a rising edge
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise_w |=> (count_w == '0));
endmodule

bind pulse_width_meter pulse_width_meter_chk #(.OUT_W(OUT_W), .SRC_W(SRC_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done_o       (done_o),
  .result_o     (result_o),
  .result_src_o (result_src_o),
  .count_en_o   (count_en_o),
  .gate_rise_w  (gate_rise_w),
  .gate_fall_w  (gate_fall_w),
  .measuring_w  (measuring_w),
  .fmt_w        (fmt_w),
  .sign_w       (sign_w),
  .count_w      (count_w)
);

// File: tb/test_pulse_width_meter.sv
module test_pulse_width_meter;
  localparam int OW = 10;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gate_i = 1'b0;
  logic          polarity_i = 1'b0;
  logic [SW-1:0] src_sel_i = '0;
  logic          unipolar_i = 1'b0;
  logic          tick_slow_i = 1'b0;
  logic          tick_fast_i = 1'b0;
  logic [OW-1:0] result_o;
  logic [SW-1:0] result_src_o;
  logic          done_o;
  logic          count_en_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pulse_width_meter i_pulse_width_meter (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .polarity_i(polarity_i),
    .src_sel_i(src_sel_i), .unipolar_i(unipolar_i),
    .tick_slow_i(tick_slow_i), .tick_fast_i(tick_fast_i),
    .result_o(result_o), .result_src_o(result_src_o),
    .done_o(done_o), .count_en_o(count_en_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected word from the format rules
  function automatic int exp_word(input bit uni, input bit neg, input int ticks);
    if (uni) begin
      if (neg) return 0;
      return (ticks > 1023) ? 1023 : ticks;
    end
    return (neg ? 512 : 0) + ((ticks > 511) ? 511 : ticks);
  endfunction

  function automatic bit coin(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  // Called at a negedge; leaves at a negedge
  task automatic pulse(input int len, input bit uni, input bit neg, input int src,
                       input int p_slow, input int p_fast, input bit scramble,
                       input bit back_to_back);
    int ticks = 0;
    bit sel;
    int prev_res = int'(result_o);
    int prev_src = int'(result_src_o);
    gate_i = 1'b1; unipolar_i = uni; polarity_i = neg; src_sel_i = SW'(src);
    for (int j = 0; j < len; j++) begin
      tick_slow_i = coin(p_slow);
      tick_fast_i = coin(p_fast);
      if (scramble && j > 0) begin
        unipolar_i = ~uni; polarity_i = ~neg; src_sel_i = SW'(src + 1);
      end
      #1;
      sel = uni ? tick_fast_i : tick_slow_i;
      chk(count_en_o == (j > 0 && sel), "R9 count_en in pulse", count_en_o, (j > 0 && sel));
      if (j > 0 && sel) ticks++;
      @(negedge clk);
    end
    chk(result_o == OW'(prev_res) && result_src_o == SW'(prev_src),
        "R8 hold during pulse", result_o, prev_res);
    gate_i = 1'b0;
    tick_slow_i = 1'b1; tick_fast_i = 1'b1;
    #1;
    chk(count_en_o == 1'b0, "R9 count_en on fall", count_en_o, 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R7 done after fall", done_o, 1);
    chk(result_o == OW'(exp_word(uni, neg, ticks)), "R2 R3 R4 R5 R6 result word",
        result_o, exp_word(uni, neg, ticks));
    chk(result_src_o == SW'(src), "R10 source tag", result_src_o, src);
    if (back_to_back) return;
    tick_slow_i = 1'b0; tick_fast_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    chk(result_o == OW'(exp_word(uni, neg, ticks)), "R8 hold after done",
        result_o, exp_word(uni, neg, ticks));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(result_o == '0 && done_o == 1'b0 && count_en_o == 1'b0, "R1 in reset", result_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick_slow_i = 1'b1; tick_fast_i = 1'b1;
    @(negedge clk);
    #1;
    chk(result_o == '0 && result_src_o == '0 && done_o == 1'b0 && count_en_o == 1'b0,
        "R1 after reset", result_o, 0);
    tick_slow_i = 1'b0; tick_fast_i = 1'b0;
    @(negedge clk);

    // Directed corners
    pulse(1, 1'b0, 1'b1, 2, 100, 100, 1'b0, 1'b0);     // R2 one-cycle pulse: count 0, sign kept
    pulse(20, 1'b0, 1'b0, 1, 0, 100, 1'b0, 1'b0);      // R3 fast ticks ignored in signed format
    pulse(20, 1'b1, 1'b0, 3, 100, 0, 1'b0, 1'b0);      // R4 slow ticks ignored in magnitude format
    pulse(30, 1'b1, 1'b1, 0, 100, 100, 1'b0, 1'b0);    // R6 negative clamps to zero
    pulse(25, 1'b0, 1'b1, 1, 60, 60, 1'b1, 1'b0);      // R2 mid-pulse changes have no effect
    pulse(25, 1'b1, 1'b0, 2, 60, 60, 1'b1, 1'b0);      // R2 scramble in magnitude format
    pulse(600, 1'b0, 1'b1, 3, 100, 0, 1'b0, 1'b0);     // R5 signed saturation at 511
    pulse(1100, 1'b1, 1'b0, 1, 0, 100, 1'b0, 1'b0);    // R5 magnitude saturation at 1023
    pulse(513, 1'b0, 1'b0, 0, 100, 0, 1'b0, 1'b0);     // R5 exactly 512 ticks -> 511
    pulse(10, 1'b0, 1'b0, 2, 100, 0, 1'b0, 1'b1);      // back to back, restart right after fall
    pulse(12, 1'b1, 1'b0, 3, 0, 100, 1'b0, 1'b0);      // R2 count cleared on restart

    // Random pulses
    for (int k = 0; k < 60; k++) begin
      pulse(1 + int'($urandom % 80), 1'($urandom), 1'($urandom), int'($urandom % 4),
            int'($urandom % 101), int'($urandom % 101), 1'($urandom), 1'b0);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule